// File: doc/BRIEF.md
# Slave Serial Audio Transmitter with Start-up Muting

This block turns two parallel 16-bit two's complement channel words into a single serial data line for an external receiver that supplies both the bit clock and the frame (channel) clock. Each frame holds exactly 32 bit clocks, 16 per channel, with no padding. A format pin selects between MSB-justified framing and I2S framing. The two formats differ in frame-clock polarity and in where the MSB sits relative to the frame-clock edge.

The block runs on a fast system clock. It samples the bit clock, the frame clock and the power control pin through synchronisers and acts on the detected edges. A load strobe writes a new pair of words into a pending register. That pair is committed at the next left-channel start, so a load in the middle of a frame never corrupts the frame being sent. While power is held off, the line stays low. After power is enabled, every channel carries zero until a set number of frame-clock rising edges has been counted.

Top module: `sdo_serial_tx`

## Requirements
- R1: Every frame is 32 bit-clock slots long. Each channel period covers 16 slots, starting at a frame-clock transition seen at a bit-clock falling edge.
- R2: Each word is sent MSB first, bit 15 down to bit 0, as the unaltered two's complement value.
- R3: With `fmt_i2s` = 0 (MSB-justified), frame clock high marks the left channel and low marks the right. The MSB is driven in the first slot after the frame-clock transition.
- R4: With `fmt_i2s` = 1 (I2S), frame clock low marks the left channel and high marks the right. The MSB is driven in the second slot of its period. The LSB is driven in the first slot of the following channel period.
- R5: `sdata` changes only in response to a detected bit-clock falling edge, or when power is removed. It is stable while the bit clock is high.
- R6: While `power_up` is low, `sdata` is 0.
- R7: After `power_up` goes high, frame-clock rising edges are counted. A channel period that starts while fewer than INIT_FRAMES rising edges were seen before its own edge carries zero. Later periods carry data. Dropping `power_up` restarts the count.
- R8: A `word_load` pulse latches both words into a pending pair. The pair is committed at the next left-channel start and used for that whole frame. A load during a frame affects only the following frame.
- R9: After synchronous reset, `sdata` is 0 and the mute count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Externally supplied bit clock (32 per frame) |
| lrck_in | input | 1 | Externally supplied frame clock |
| fmt_i2s | input | 1 | 0: MSB-justified, 1: I2S |
| power_up | input | 1 | 0: powered down, line held low; 1: running |
| word_left | input | 16 | Left-channel word, two's complement |
| word_right | input | 16 | Right-channel word, two's complement |
| word_load | input | 1 | Strobe latching both words into the pending pair |
| sdata | output | 1 | Serial data output |

## Verification
Both formats are driven with a walking-one left word against a walking-zero right word, so a one-slot shift, a swapped channel or a lost LSB shows up as a distinct bit error. Full-scale values 0x8000, 0x7FFF, 0xFFFF and 0x0001 test sign and end bits. A load placed mid-frame separates commit-at-frame-start from immediate capture. Power-down and re-enable bursts check that the muted periods end exactly at the counted edge, separately for the format where that edge starts a left period and the one where it starts a right period.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  typedef enum logic {
    FMT_MSBJ = 1'b0,
    FMT_I2S  = 1'b1
  } fmt_e;

  // Frame-clock level that marks the left channel in each format
  function automatic logic left_level(input fmt_e f);
    return (f == FMT_MSBJ);
  endfunction
endpackage

// File: rtl/sdo_sync.sv
module sdo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sdo_clk_track.sv
module sdo_clk_track #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic power_up,
  output logic bclk_fall,
  output logic lrck_lvl,
  output logic lrck_rise,
  output logic pd_ok
);
  logic [2:0] raw, synced;
  logic       bclk_d, lrck_d;

  assign raw = {power_up, lrck_in, bclk_in};

  sdo_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      lrck_d <= 1'b0;
    end else begin
      bclk_d <= synced[0];
      lrck_d <= synced[1];
    end
  end

  assign bclk_fall = bclk_d & ~synced[0];
  assign lrck_lvl  = synced[1];
  assign lrck_rise = ~lrck_d & synced[1];
  assign pd_ok     = synced[2];
endmodule

// File: rtl/sdo_init_mute.sv
module sdo_init_mute #(
  parameter int INIT_FRAMES = 4128
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_ok,
  input  logic lrck_rise,
  output logic live
);
  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_FRAMES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pd_ok)                    cnt <= '0;
    else if (lrck_rise && (cnt != LIMIT)) cnt <= cnt + 1'b1;
  end

  // Count seen before the current cycle's edge decides the period
  assign live = (cnt == LIMIT);
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
  import sdo_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_ok,
  input  logic              bclk_fall,
  input  logic              lrck_lvl,
  input  logic              fmt_i2s,
  input  logic              live,
  input  logic [WORD_W-1:0] word_l,
  input  logic [WORD_W-1:0] word_r,
  output logic              chan_start,
  output logic              is_left,
  output logic              sdata
);
  fmt_e              fmt;
  logic              lrck_prev;
  logic [WORD_W-1:0] sh, wsel;
  logic              sd_q;

  assign fmt        = fmt_e'(fmt_i2s);
  assign chan_start = bclk_fall && (lrck_lvl != lrck_prev);
  assign is_left    = (lrck_lvl == left_level(fmt));
  assign wsel       = !live ? '0 : (is_left ? word_l : word_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_prev <= 1'b0;
      sh        <= '0;
      sd_q      <= 1'b0;
    end else begin
      if (bclk_fall) lrck_prev <= lrck_lvl;
      if (!pd_ok) begin
        sh   <= '0;
        sd_q <= 1'b0;
      end else if (bclk_fall) begin
        if (chan_start) begin
          if (fmt == FMT_I2S) begin
            // spill previous LSB, hold full new word for next slots
            sd_q <= sh[WORD_W-1];
            sh   <= wsel;
          end else begin
            sd_q <= wsel[WORD_W-1];
            sh   <= {wsel[WORD_W-2:0], 1'b0};
          end
        end else begin
          sd_q <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdata = sd_q;
endmodule

// File: rtl/sdo_serial_tx.sv
module sdo_serial_tx #(
  parameter int WORD_W      = 16,
  parameter int INIT_FRAMES = 4128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              lrck_in,
  input  logic              fmt_i2s,
  input  logic              power_up,
  input  logic [WORD_W-1:0] word_left,
  input  logic [WORD_W-1:0] word_right,
  input  logic              word_load,
  output logic              sdata
);
  logic              bclk_fall, lrck_lvl, lrck_rise, pd_ok, live;
  logic              chan_start, is_left, frame_start;
  logic [WORD_W-1:0] pend_l, pend_r, act_r;

  sdo_clk_track #(.SYNC_STAGES(SYNC_STAGES)) i_track (
    .clk      (clk),
    .rst      (rst),
    .bclk_in  (bclk_in),
    .lrck_in  (lrck_in),
    .power_up (power_up),
    .bclk_fall(bclk_fall),
    .lrck_lvl (lrck_lvl),
    .lrck_rise(lrck_rise),
    .pd_ok    (pd_ok)
  );

  sdo_init_mute #(.INIT_FRAMES(INIT_FRAMES)) i_mute (
    .clk      (clk),
    .rst      (rst),
    .pd_ok    (pd_ok),
    .lrck_rise(lrck_rise),
    .live     (live)
  );

  // Pending pair written by the strobe; right word committed per frame
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l <= '0;
      pend_r <= '0;
      act_r  <= '0;
    end else begin
      if (word_load) begin
        pend_l <= word_left;
        pend_r <= word_right;
      end
      if (frame_start) act_r <= pend_r;
    end
  end

  assign frame_start = chan_start && is_left;

  sdo_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .pd_ok     (pd_ok),
    .bclk_fall (bclk_fall),
    .lrck_lvl  (lrck_lvl),
    .fmt_i2s   (fmt_i2s),
    .live      (live),
    .word_l    (pend_l),
    .word_r    (act_r),
    .chan_start(chan_start),
    .is_left   (is_left),
    .sdata     (sdata)
  );
endmodule

// File: rtl/sdo_serial_tx_chk.sv
module sdo_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic pd_ok,
  input logic bclk_fall,
  input logic lrck_rise,
  input logic live,
  input logic chan_start,
  input logic fmt_i2s,
  input logic sdata
);
  // R6: line low once powered down
  a_r6_pd_zero: assert property (@(posedge clk) disable iff (rst)
    !pd_ok |=> !sdata);

  // R5: output moves only on a bit-clock fall or power removal
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> ($past(bclk_fall) || !$past(pd_ok)));

  // R7: mute ends only on a counted frame-clock rise
  a_r7_unmute_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(live) |-> $past(lrck_rise));

  // R7: mute restarts only through power-down
  a_r7_remute_on_pd: assert property (@(posedge clk) disable iff (rst)
    $fell(live) |-> !$past(pd_ok));

  // R7 with R3: a muted MSB-justified period begins with a zero MSB
  a_r7_muted_msb: assert property (@(posedge clk) disable iff (rst)
    (chan_start && !live && !fmt_i2s) |=> !sdata);
endmodule

bind sdo_serial_tx sdo_serial_tx_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .pd_ok     (pd_ok),
  .bclk_fall (bclk_fall),
  .lrck_rise (lrck_rise),
  .live      (live),
  .chan_start(chan_start),
  .fmt_i2s   (fmt_i2s),
  .sdata     (sdata)
);

// File: tb/test_sdo_serial_tx.sv
module test_sdo_serial_tx;
  localparam int W = 16;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b1, lrck = 1'b0, fmt = 1'b0, pwr = 1'b0, load = 1'b0;
  logic [W-1:0] wl = '0, wr = '0;
  logic sd;

  always #2 clk = ~clk;

  sdo_serial_tx #(.WORD_W(W), .INIT_FRAMES(N), .SYNC_STAGES(2)) i_sdo_serial_tx (
    .clk(clk), .rst(rst), .bclk_in(bclk), .lrck_in(lrck), .fmt_i2s(fmt),
    .power_up(pwr), .word_left(wl), .word_right(wr), .word_load(load), .sdata(sd)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic  bits [0:8191];
  int    nbits;
  int    ps [0:511];
  logic [W-1:0] pw [0:511];
  bit    pc [0:511];
  string ptg [0:511];
  int    np;

  // model state
  logic [W-1:0] pend_l, pend_r, act_l, act_r;
  int   cnt;
  logic lrck_m;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic lv, input bit do_ld, input logic [W-1:0] nl, input logic [W-1:0] nr);
    logic first;
    @(negedge clk);
    bclk = 1'b0;
    lrck = lv;
    repeat (8) @(negedge clk);
    first = sd;
    bits[nbits] = sd;
    nbits++;
    bclk = 1'b1;
    if (do_ld) begin
      load = 1'b1; wl = nl; wr = nr;
      pend_l = nl; pend_r = nr;
    end
    @(negedge clk);
    load = 1'b0;
    repeat (6) @(negedge clk);
    chk(sd === first, "R5 stable while bit clock high", {15'd0, sd}, {15'd0, first});
  endtask

  task automatic open_period(input logic lv, input logic [W-1:0] w, input string tag);
    bit live;
    live = pwr && (cnt >= N);
    if (lv && !lrck_m && pwr) cnt++;
    lrck_m = lv;
    ps[np]  = nbits;
    pw[np]  = live ? w : '0;
    pc[np]  = 1'b1;
    ptg[np] = !pwr ? "R6 powered down" : (live ? tag : "R7 muted");
    np++;
  endtask

  // R1: 32 slots, left half then right half
  task automatic run_frame(input int ld_slot, input logic [W-1:0] nl, input logic [W-1:0] nr, input string tag);
    logic ll, lv;
    ll = ~fmt;
    act_l = pend_l;
    act_r = pend_r;
    for (int s = 0; s < 32; s++) begin
      lv = (s < 16) ? ll : ~ll;
      if (s == 0)  open_period(lv, act_l, tag);
      if (s == 16) open_period(lv, act_r, tag);
      slot(lv, s == ld_slot, nl, nr);
    end
  endtask

  task automatic load_words(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    load = 1'b1; wl = l; wr = r;
    pend_l = l; pend_r = r;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic set_power(input logic p);
    if (!p && np > 0) pc[np-1] = 1'b0; // I2S LSB spill would land in power-down
    @(negedge clk);
    pwr = p;
    if (!p) cnt = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic f);
    @(negedge clk);
    rst = 1'b1; pwr = 1'b0; fmt = f; bclk = 1'b1; lrck = f; load = 1'b0;
    lrck_m = f;
    nbits = 0; np = 0; cnt = 0;
    pend_l = '0; pend_r = '0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(sd === 1'b0, "R9 reset state", {15'd0, sd}, '0);
  endtask

  task automatic check_all();
    int off;
    logic [W-1:0] got;
    off = fmt ? 1 : 0;
    for (int p = 0; p < np; p++) begin
      if (pc[p] && (ps[p] + off + W - 1 < nbits)) begin
        for (int i = 0; i < W; i++) got[W-1-i] = bits[ps[p] + off + i];
        chk(got === pw[p], ptg[p], got, pw[p]);
      end
    end
  endtask

  task automatic run_format(input logic f);
    string tg;
    tg = f ? "R4 I2S R2" : "R3 MSB-justified R2";
    do_reset(f);
    // R6: data loaded while powered down must not appear
    load_words(16'h1234, 16'hFEDC);
    run_frame(-1, '0, '0, tg);
    run_frame(-1, '0, '0, tg);
    set_power(1'b1);
    // R7 muted start, then R2/R3/R4 walking patterns
    for (int k = 0; k < W; k++) begin
      load_words(16'h0001 << k, ~(16'h8000 >> k));
      run_frame(-1, '0, '0, tg);
    end
    load_words(16'h8000, 16'h7FFF);
    run_frame(-1, '0, '0, tg);
    load_words(16'hFFFF, 16'h0001);
    run_frame(-1, '0, '0, tg);
    // R8: load mid-frame lands in the next frame only
    load_words(16'h0F0F, 16'hF0F0);
    run_frame(10, 16'hA5C3, 16'h3C5A, "R8 current frame kept");
    run_frame(-1, '0, '0, "R8 next frame updated");
    // R6 then R7 restart
    set_power(1'b0);
    run_frame(-1, '0, '0, tg);
    run_frame(-1, '0, '0, tg);
    set_power(1'b1);
    for (int k = 0; k < 6; k++) begin
      load_words(16'h1111 * (k + 1), 16'h2468 ^ k[15:0]);
      run_frame(-1, '0, '0, "R7 after restart");
    end
    run_frame(-1, '0, '0, tg);
    check_all();
  endtask

  initial begin
    run_format(1'b0);
    run_format(1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule